// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects sixteen single-cycle event pulses from the timers, the serial port and the general-purpose pins of a multi-function peripheral. It drives one interrupt request line towards the CPU. Each source owns one bit in four 16-bit registers: enable, pending, mask and in-service. An 8-bit vector register holds a 4-bit vector base and the end-of-interrupt mode bit. Software reaches all of these through a byte-wide port. Writes take effect at the clock edge. Reads are combinational.

When the CPU strobes acknowledge, the block looks at the highest-numbered source that is both pending and eligible. It returns a vector made of the base followed by that source number. If no source is eligible, it raises a no-vector flag instead. In software end-of-interrupt mode, an acknowledge moves the source from pending to in-service. An in-service source then holds back every lower-numbered request until software clears its in-service bit.

Top module: `irq_vector_ctrl`

## Requirements
- R1: An event pulse on `src_evt[i]` sets pending bit i at the next clock edge only if enable bit i is 1 in that cycle. An event on a disabled source leaves no trace.
- R2: `irq_out` is 1 exactly when some pending bit that is also set in the mask register is eligible. Pending bits with mask 0 never raise it.
- R3: A write that clears enable bit i also clears pending bit i at the same clock edge.
- R4: A write to a pending byte is ANDed into that byte. A 0 clears the bit and a 1 leaves it unchanged, so a write can never set a pending bit.
- R5: Source i has priority over source j when i > j. During `ack_strobe`, `ack_vector` = {vector register bits 7:4, 4-bit winning source number}.
- R6: An acknowledge while no source is eligible gives `ack_none` = 1 and `ack_vector` = 0. It changes no register.
- R7: With mode bit 3 of the vector register at 1, an acknowledge clears the winner's pending bit and sets its in-service bit. In-service writes are ANDed like pending writes, so the bit stays set until software writes a 0 to it.
- R8: With bit 3 at 1 and any in-service bit set, let k be the highest set in-service bit. Only pending and masked sources numbered k or higher are eligible.
- R9: With bit 3 at 0, an acknowledge clears only the winner's pending bit. The in-service register is left unchanged and has no effect on eligibility.
- R10: Byte offsets on `reg_addr`:
  - 0/1: enable low/high
  - 2/3: pending low/high
  - 4/5: in-service low/high
  - 6/7: mask low/high
  - 8: vector register

  Enable, mask and vector bytes are written as given. All of these read back their current contents. Other offsets read 0.
- R11: After reset all registers are 0, `irq_out` is 0 and both acknowledge outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 16 | Single-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| ack_strobe | input | 1 | CPU acknowledge, one cycle |
| ack_vector | output | 8 | Vector returned during an acknowledge |
| ack_none | output | 1 | Acknowledge found nothing eligible |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The hardest situation to reach from the ports is the one with several in-service levels held at once. A lower source waits behind them, and an equal-priority repeat arrives. To build it, the bench switches on software end-of-interrupt mode and acknowledges a middle source. It then posts a lower and an equal source and acknowledges a higher one. After that it retires the in-service bits one at a time through AND writes. After each step it reads the request line and the acknowledge result. A final pass turns the mode bit off while an in-service bit is still set. This shows the stale bit no longer blocks anything.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  localparam int DW   = 8;
  localparam int NSRC = 2 * DW;
  localparam int IDW  = $clog2(NSRC);
  localparam int AW   = 4;
  localparam int VEC_MODE_BIT = 3;
  localparam int VBW  = DW - IDW;

  localparam logic [AW-2:0] SEL_EN   = 3'd0;
  localparam logic [AW-2:0] SEL_PEND = 3'd1;
  localparam logic [AW-2:0] SEL_ISR  = 3'd2;
  localparam logic [AW-2:0] SEL_MASK = 3'd3;
  localparam logic [AW-1:0] ADDR_VEC = 4'd8;

  // index of the highest set bit (0 when none)
  function automatic logic [IDW-1:0] top_index(input logic [NSRC-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (v[i]) r = IDW'(i);
    return r;
  endfunction

  // ones at every position at or above idx
  function automatic logic [NSRC-1:0] at_or_above(input logic [IDW-1:0] idx);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++)
      r[i] = (i >= int'(idx));
    return r;
  endfunction

  // AND mask for a byte-lane write; all ones when not hit
  function automatic logic [NSRC-1:0] lane_and(input logic hit, input logic lane,
                                               input logic [DW-1:0] d);
    logic [NSRC-1:0] r;
    r = '1;
    if (hit) begin
      if (lane) r[NSRC-1:DW] = d;
      else      r[DW-1:0]    = d;
    end
    return r;
  endfunction

  // byte-lane replace
  function automatic logic [NSRC-1:0] lane_put(input logic [NSRC-1:0] old, input logic hit,
                                               input logic lane, input logic [DW-1:0] d);
    logic [NSRC-1:0] r;
    r = old;
    if (hit) begin
      if (lane) r[NSRC-1:DW] = d;
      else      r[DW-1:0]    = d;
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_vc_resolve.sv
module irq_vc_resolve
  import irq_vc_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] isr,
  input  logic            sw_eoi,
  output logic [NSRC-1:0] eligible,
  output logic            any_eligible,
  output logic [IDW-1:0]  win_idx
);
  logic [NSRC-1:0] floor_mask;

  always_comb begin
    if (sw_eoi && (|isr)) floor_mask = at_or_above(top_index(isr));
    else                  floor_mask = '1;
    eligible     = pend & mask & floor_mask;
    any_eligible = |eligible;
    win_idx      = top_index(eligible);
  end
endmodule

// File: rtl/irq_vc_regs.sv
module irq_vc_regs
  import irq_vc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] src_evt,
  input  logic            ack_take,
  input  logic [IDW-1:0]  ack_idx,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] isr_q,
  output logic [DW-1:0]   vec_q
);
  logic            lane;
  logic [AW-2:0]   sel;
  logic            hit_en, hit_pend, hit_isr, hit_mask, hit_vec;
  logic [NSRC-1:0] ack_onehot;
  logic [NSRC-1:0] en_n, pend_n, mask_n, isr_n;

  assign lane = wr_addr[0];
  assign sel  = wr_addr[AW-1:1];

  always_comb begin
    hit_en   = wr_en && (sel == SEL_EN);
    hit_pend = wr_en && (sel == SEL_PEND);
    hit_isr  = wr_en && (sel == SEL_ISR);
    hit_mask = wr_en && (sel == SEL_MASK);
    hit_vec  = wr_en && (wr_addr == ADDR_VEC);
    ack_onehot = ack_take ? (NSRC'(1) << ack_idx) : '0;

    en_n   = lane_put(en_q, hit_en, lane, wr_data);
    mask_n = lane_put(mask_q, hit_mask, lane, wr_data);
    pend_n = ((pend_q & lane_and(hit_pend, lane, wr_data) & ~ack_onehot)
              | (src_evt & en_q)) & en_n;
    isr_n  = (isr_q & lane_and(hit_isr, lane, wr_data))
             | (vec_q[VEC_MODE_BIT] ? ack_onehot : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      mask_q <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
      mask_q <= mask_n;
      isr_q  <= isr_n;
      if (hit_vec) vec_q <= wr_data;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     src_evt,
  input  logic            reg_we,
  input  logic [3:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            ack_strobe,
  output logic [7:0]      ack_vector,
  output logic            ack_none,
  output logic            irq_out
);
  logic [NSRC-1:0] en_q, pend_q, mask_q, isr_q, eligible;
  logic [DW-1:0]   vec_q;
  logic            any_eligible, ack_take, sw_eoi;
  logic [IDW-1:0]  win_idx;

  assign sw_eoi   = vec_q[VEC_MODE_BIT];
  assign ack_take = ack_strobe && any_eligible;

  irq_vc_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .src_evt(src_evt), .ack_take(ack_take), .ack_idx(win_idx),
    .en_q(en_q), .pend_q(pend_q), .mask_q(mask_q), .isr_q(isr_q), .vec_q(vec_q)
  );

  irq_vc_resolve u_resolve (
    .pend(pend_q), .mask(mask_q), .isr(isr_q), .sw_eoi(sw_eoi),
    .eligible(eligible), .any_eligible(any_eligible), .win_idx(win_idx)
  );

  assign irq_out    = any_eligible;
  assign ack_none   = ack_strobe && !any_eligible;
  assign ack_vector = ack_take ? {vec_q[DW-1:IDW], win_idx} : '0;

  always_comb begin
    unique case (reg_addr)
      4'd0:    reg_rdata = en_q[DW-1:0];
      4'd1:    reg_rdata = en_q[NSRC-1:DW];
      4'd2:    reg_rdata = pend_q[DW-1:0];
      4'd3:    reg_rdata = pend_q[NSRC-1:DW];
      4'd4:    reg_rdata = isr_q[DW-1:0];
      4'd5:    reg_rdata = isr_q[NSRC-1:DW];
      4'd6:    reg_rdata = mask_q[DW-1:0];
      4'd7:    reg_rdata = mask_q[NSRC-1:DW];
      ADDR_VEC: reg_rdata = vec_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] src_evt,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic        ack_strobe,
  input logic        ack_none,
  input logic        irq_out,
  input logic [15:0] en_q,
  input logic [15:0] pend_q,
  input logic [15:0] mask_q,
  input logic [15:0] isr_q,
  input logic [7:0]  vec_q
);
  assert_line_needs_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((pend_q & mask_q) != 16'h0));

  assert_disabled_not_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~en_q) == 16'h0);

  assert_pend_write_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[3:1] == 3'd1 && src_evt == 16'h0)
      |=> ((pend_q & ~$past(pend_q)) == 16'h0));

  assert_idle_ack_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && !irq_out) |-> ack_none);

  assert_seoi_ack_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && !ack_none && vec_q[3]) |=> (isr_q != 16'h0));

  assert_aeoi_isr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && !vec_q[3] && !reg_we) |=> $stable(isr_q));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we), .reg_addr(reg_addr),
  .ack_strobe(ack_strobe), .ack_none(ack_none), .irq_out(irq_out),
  .en_q(en_q), .pend_q(pend_q), .mask_q(mask_q), .isr_q(isr_q), .vec_q(vec_q)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_evt = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        ack_strobe = 1'b0;
  logic [7:0]  ack_vector;
  logic        ack_none;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_strobe(ack_strobe),
    .ack_vector(ack_vector), .ack_none(ack_none), .irq_out(irq_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] base, input logic [15:0] d);
    wr(base, d[7:0]);
    wr(base + 4'd1, d[15:8]);
  endtask

  task automatic rd16(input logic [3:0] base, output logic [15:0] v);
    @(negedge clk);
    reg_addr = base;       #1; v[7:0]  = reg_rdata;
    reg_addr = base + 4'd1; #1; v[15:8] = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk);
    src_evt = e;
    @(posedge clk); #1;
    src_evt = '0;
  endtask

  task automatic ack(output logic [7:0] vec, output logic none);
    @(negedge clk);
    ack_strobe = 1'b1; #1;
    vec = ack_vector; none = ack_none;
    @(posedge clk); #1;
    ack_strobe = 1'b0;
  endtask

  task automatic chk_line(input string req, input logic exp);
    @(negedge clk); #1;
    check(req, int'(irq_out), int'(exp));
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 8; a += 2) begin
      rd16(4'(a), v);
      check("R11 reg zero", int'(v), 0);
    end
    check("R11 irq low", int'(irq_out), 0);
    check("R11 ack_none low", int'(ack_none), 0);
  endtask

  task automatic t_enable_gate;
    logic [15:0] v;
    wr16(4'd0, 16'h0001);
    pulse(16'h0003);
    rd16(4'd2, v);
    check("R1 only enabled source pends", int'(v), 16'h0001);
  endtask

  task automatic t_mask;
    chk_line("R2 masked pending keeps line low", 1'b0);
    wr16(4'd6, 16'h0001);
    chk_line("R2 unmasked pending raises line", 1'b1);
  endtask

  task automatic t_pending_write;
    logic [15:0] v;
    wr16(4'd0, 16'h0003);
    pulse(16'h0003);
    wr(4'd2, 8'hFE);
    rd16(4'd2, v);
    check("R4 zero clears pending", int'(v), 16'h0002);
    wr(4'd2, 8'hFF);
    wr(4'd3, 8'hFF);
    rd16(4'd2, v);
    check("R4 ones never set pending", int'(v), 16'h0002);
  endtask

  task automatic t_enable_clear;
    logic [15:0] v;
    wr(4'd0, 8'h01);
    rd16(4'd2, v);
    check("R3 disable clears pending", int'(v), 16'h0000);
  endtask

  task automatic t_priority;
    logic [7:0] vec; logic none;
    wr(4'd8, 8'hA0);
    wr16(4'd0, 16'hFFFF);
    wr16(4'd6, 16'hFFFF);
    pulse(16'h2204);
    ack(vec, none);
    check("R5 highest first", int'(vec), 8'hAD);
    ack(vec, none);
    check("R5 next", int'(vec), 8'hA9);
    ack(vec, none);
    check("R5 lowest", int'(vec), 8'hA2);
    ack(vec, none);
    check("R6 none flag", int'(none), 1);
    check("R6 vector zero", int'(vec), 0);
    chk_line("R2 line drops when empty", 1'b0);
  endtask

  task automatic t_seoi;
    logic [7:0] vec; logic none; logic [15:0] v;
    wr(4'd8, 8'h58);
    rd16(4'd8, v);
    check("R10 vector readback", int'(v[7:0]), 8'h58);
    pulse(16'h0100);
    ack(vec, none);
    check("R7 vector", int'(vec), 8'h58);
    rd16(4'd4, v);
    check("R7 in-service set", int'(v), 16'h0100);
    rd16(4'd2, v);
    check("R7 pending cleared", int'(v), 16'h0000);
    pulse(16'h0010);
    chk_line("R8 lower blocked", 1'b0);
    ack(vec, none);
    check("R8 lower gives none", int'(none), 1);
    pulse(16'h0100);
    chk_line("R8 equal passes", 1'b1);
    pulse(16'h1000);
    ack(vec, none);
    check("R8 higher wins", int'(vec), 8'h5C);
    rd16(4'd4, v);
    check("R7 two in-service", int'(v), 16'h1100);
    wr(4'd5, 8'hFF);
    rd16(4'd4, v);
    check("R7 ones keep in-service", int'(v), 16'h1100);
    wr(4'd5, 8'hEF);
    rd16(4'd4, v);
    check("R7 zero clears in-service", int'(v), 16'h0100);
    ack(vec, none);
    check("R8 equal acked", int'(vec), 8'h58);
    wr(4'd5, 8'hFE);
    chk_line("R8 lower released", 1'b1);
    ack(vec, none);
    check("R8 lower acked", int'(vec), 8'h54);
    rd16(4'd4, v);
    check("R7 lower in-service", int'(v), 16'h0010);
    wr(4'd4, 8'h00);
  endtask

  task automatic t_aeoi;
    logic [7:0] vec; logic none; logic [15:0] v;
    pulse(16'h0400);
    ack(vec, none);
    check("R7 setup", int'(vec), 8'h5A);
    wr(4'd8, 8'h50);
    pulse(16'h0002);
    chk_line("R9 stale in-service ignored", 1'b1);
    ack(vec, none);
    check("R9 vector", int'(vec), 8'h51);
    rd16(4'd4, v);
    check("R9 in-service untouched", int'(v), 16'h0400);
    rd16(4'd2, v);
    check("R9 pending cleared", int'(v), 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    t_reset();
    t_enable_gate();
    t_mask();
    t_pending_write();
    t_enable_clear();
    t_priority();
    t_seoi();
    t_aeoi();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule